// File: doc/BRIEF.md
# Host Command Mailbox Register Block

This block is the device-side register front end of a command mailbox shared by an external host and an embedded acquisition processor. The host sees three byte-wide registers through a simple index-plus-strobe port: a buffer pointer, a buffer data window and a status/control byte. A transfer starts with a write of 0 to the pointer. The host then streams the command byte, the message-ID byte and the payload through the data window, with the pointer advancing on its own after each access. It then raises the request-busy flag and polls until the processor has dropped it.

The processor has a plain RAM port into the same buffer and a clear strobe for the busy flag. It reads the request, writes the response (the same two header bytes, then its payload) from address 0, and clears the flag. The host then reloads the pointer with 0 and reads the response back through the data window. The busy flag only moves on a host write if the load-enable bit of the same byte is set, so a status write cannot raise or drop it by accident.

Top module: `cmd_mailbox`

## Requirements
- R1: After reset the busy flag is 0, the pointer is 0 and `host_rdata` is 0x00.
- R2: A host write to index `IDX_PTR` (default 0xA6) loads the pointer with the low log2(DEPTH) bits of the byte. A host read of that index returns the pointer, zero-extended, on `host_rdata` one cycle after the strobe, and leaves the pointer unchanged.
- R3: A host write to index `IDX_DAT` (default 0xA7) stores the byte at the pointer and then advances the pointer by one.
- R4: A host read of `IDX_DAT` returns the byte at the pointer on `host_rdata` one cycle after the strobe, and then advances the pointer by one.
- R5: The pointer wraps from DEPTH-1 to 0 when a data access advances it.
- R6: A host write to index `IDX_STS` (default 0xA8) copies bit `FLAG_BIT` (default 0) into the busy flag only when bit `LOAD_BIT` (default 1) of the same byte is 1. Otherwise the flag keeps its value.
- R7: A host read of `IDX_STS` returns the busy flag at bit `FLAG_BIT`, with every other bit 0. This includes the load-enable bit.
- R8: `proc_clr` clears the busy flag on the next edge. If a host status write sets the flag in the same cycle, the clear wins.
- R9: A processor write (`proc_we`) stores `proc_wdata` at `proc_addr`. `proc_rdata` shows the byte at `proc_addr` one cycle after that address is presented. The host and the processor each see the other's writes.
- R10: If a processor write and a host data write target the same buffer location in the same cycle, the processor byte is stored. The host pointer still advances.
- R11: A host write to any other index changes nothing: the pointer, the flag and the buffer all keep their values. A host read of any other index returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe (a write in the same cycle takes priority) |
| host_idx | input | IDX_W | Host register index |
| host_wdata | input | DW | Host write byte |
| host_rdata | output | DW | Host read byte, valid the cycle after a read strobe |
| proc_we | input | 1 | Processor buffer write enable |
| proc_addr | input | AW | Processor buffer address |
| proc_wdata | input | DW | Processor write byte |
| proc_rdata | output | DW | Processor read byte, registered from `proc_addr` |
| proc_clr | input | 1 | Processor completion strobe that clears the busy flag |
| req_busy | output | 1 | Busy flag as seen by the processor |

## Verification
The bench builds the block with DEPTH set to 16, so AW is 4 and the pointer wraps after 16 data accesses. This brings the wrap, a full-buffer round trip and a second pass through the buffer within a few hundred cycles. With the 8-bit index left at full width, every one of the 253 unmapped indices can be swept for both reads and writes. All four load-enable/flag combinations of a status write are applied from both flag states.

// File: rtl/cmd_mailbox_pkg.sv
package cmd_mailbox_pkg;
   localparam int unsigned MBX_IDX_W   = 8;
   localparam int unsigned MBX_DW      = 8;
   localparam int unsigned MBX_DEPTH   = 128;
   localparam logic [7:0]  MBX_IDX_PTR = 8'hA6;
   localparam logic [7:0]  MBX_IDX_DAT = 8'hA7;
   localparam logic [7:0]  MBX_IDX_STS = 8'hA8;
   localparam int unsigned MBX_FLAG_BIT = 0;
   localparam int unsigned MBX_LOAD_BIT = 1;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_PTR  = 2'd1,
      SEL_DAT  = 2'd2,
      SEL_STS  = 2'd3
   } mbx_sel_e;
endpackage

// File: rtl/mbx_ptr.sv
module mbx_ptr #(
   parameter int unsigned AW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_val,
   input  logic          step,
   output logic [AW-1:0] ptr
);
   localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ptr <= '0;
      else if (load) ptr <= load_val;
      else if (step) ptr <= ptr + ONE;   // natural wrap modulo 2**AW
   end
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic host_load,
   input  logic host_val,
   input  logic clr,
   output logic busy
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         busy <= 1'b0;
      else if (clr)       busy <= 1'b0;      // completion beats host write
      else if (host_load) busy <= host_val;
   end
endmodule

// File: rtl/mbx_ram.sv
module mbx_ram #(
   parameter int unsigned DEPTH = 128,
   parameter int unsigned AW    = 7,
   parameter int unsigned DW    = 8
) (
   input  logic          clk,
   input  logic          a_we,
   input  logic [AW-1:0] a_addr,
   input  logic [DW-1:0] a_wdata,
   input  logic          b_we,
   input  logic [AW-1:0] b_addr,
   input  logic [DW-1:0] b_wdata,
   output logic [DW-1:0] a_rdata,
   output logic [DW-1:0] b_rdata
);
   logic [DW-1:0] mem [DEPTH];

   for (genvar w = 0; w < DEPTH; w++) begin : g_word
      logic hit_a, hit_b;
      assign hit_a = a_we && (a_addr == AW'(w));
      assign hit_b = b_we && (b_addr == AW'(w));
      always_ff @(posedge clk) begin
         if (hit_b)      mem[w] <= b_wdata;   // port b has priority
         else if (hit_a) mem[w] <= a_wdata;
      end
   end

   assign a_rdata = mem[a_addr];
   assign b_rdata = mem[b_addr];
endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
   import cmd_mailbox_pkg::*;
#(
   parameter int unsigned IDX_W    = MBX_IDX_W,
   parameter int unsigned DW       = MBX_DW,
   parameter int unsigned DEPTH    = MBX_DEPTH,
   parameter logic [IDX_W-1:0] IDX_PTR = IDX_W'(MBX_IDX_PTR),
   parameter logic [IDX_W-1:0] IDX_DAT = IDX_W'(MBX_IDX_DAT),
   parameter logic [IDX_W-1:0] IDX_STS = IDX_W'(MBX_IDX_STS),
   parameter int unsigned FLAG_BIT = MBX_FLAG_BIT,
   parameter int unsigned LOAD_BIT = MBX_LOAD_BIT,
   localparam int unsigned AW      = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_wr,
   input  logic             host_rd,
   input  logic [IDX_W-1:0] host_idx,
   input  logic [DW-1:0]    host_wdata,
   output logic [DW-1:0]    host_rdata,
   input  logic             proc_we,
   input  logic [AW-1:0]    proc_addr,
   input  logic [DW-1:0]    proc_wdata,
   output logic [DW-1:0]    proc_rdata,
   input  logic             proc_clr,
   output logic             req_busy
);
   // elaboration-time parameter checks
   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("cmd_mailbox: DEPTH must be a power of two of at least 2");
   end
   if (AW > DW) begin : g_bad_width
      $error("cmd_mailbox: pointer must fit in a data byte");
   end
   if (FLAG_BIT >= DW || LOAD_BIT >= DW || FLAG_BIT == LOAD_BIT) begin : g_bad_bits
      $error("cmd_mailbox: flag and load bits must be distinct and inside DW");
   end
   if (IDX_PTR == IDX_DAT || IDX_PTR == IDX_STS || IDX_DAT == IDX_STS) begin : g_bad_idx
      $error("cmd_mailbox: register indices must differ");
   end

   mbx_sel_e      sel;
   logic          rd_go;
   logic [AW-1:0] ptr_q;
   logic          busy_q;
   logic [DW-1:0] host_word, proc_word;
   logic [DW-1:0] ptr_ext, sts_ext, rd_mux;

   always_comb begin
      unique case (host_idx)
         IDX_PTR: sel = SEL_PTR;
         IDX_DAT: sel = SEL_DAT;
         IDX_STS: sel = SEL_STS;
         default: sel = SEL_NONE;
      endcase
   end

   assign rd_go = host_rd && !host_wr;

   mbx_ptr #(.AW(AW)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (host_wr && sel == SEL_PTR),
      .load_val (host_wdata[AW-1:0]),
      .step     ((host_wr || host_rd) && sel == SEL_DAT),
      .ptr      (ptr_q)
   );

   mbx_flag u_flag (
      .clk       (clk),
      .rst_n     (rst_n),
      .host_load (host_wr && sel == SEL_STS && host_wdata[LOAD_BIT]),
      .host_val  (host_wdata[FLAG_BIT]),
      .clr       (proc_clr),
      .busy      (busy_q)
   );

   mbx_ram #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_ram (
      .clk     (clk),
      .a_we    (host_wr && sel == SEL_DAT),
      .a_addr  (ptr_q),
      .a_wdata (host_wdata),
      .b_we    (proc_we),
      .b_addr  (proc_addr),
      .b_wdata (proc_wdata),
      .a_rdata (host_word),
      .b_rdata (proc_word)
   );

   always_comb begin
      ptr_ext            = '0;
      ptr_ext[AW-1:0]    = ptr_q;
      sts_ext            = '0;
      sts_ext[FLAG_BIT]  = busy_q;
      unique case (sel)
         SEL_PTR: rd_mux = ptr_ext;
         SEL_DAT: rd_mux = host_word;
         SEL_STS: rd_mux = sts_ext;
         default: rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     host_rdata <= '0;
      else if (rd_go) host_rdata <= rd_mux;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) proc_rdata <= '0;
      else        proc_rdata <= proc_word;
   end

   assign req_busy = busy_q;
endmodule

// File: rtl/cmd_mailbox_chk.sv
module cmd_mailbox_chk #(
   parameter int unsigned IDX_W    = 8,
   parameter int unsigned DW       = 8,
   parameter int unsigned AW       = 7,
   parameter logic [IDX_W-1:0] IDX_PTR = 8'hA6,
   parameter logic [IDX_W-1:0] IDX_DAT = 8'hA7,
   parameter logic [IDX_W-1:0] IDX_STS = 8'hA8,
   parameter int unsigned FLAG_BIT = 0,
   parameter int unsigned LOAD_BIT = 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             host_wr,
   input logic             host_rd,
   input logic [IDX_W-1:0] host_idx,
   input logic [DW-1:0]    host_wdata,
   input logic [DW-1:0]    host_rdata,
   input logic             proc_clr,
   input logic             busy,
   input logic [AW-1:0]    ptr
);
   localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};
   logic mapped;
   assign mapped = (host_idx == IDX_PTR) || (host_idx == IDX_DAT) || (host_idx == IDX_STS);

   // R2
   ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr && host_idx == IDX_PTR |=> ptr == $past(host_wdata[AW-1:0]));

   // R3
   ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr || host_rd) && host_idx == IDX_DAT |=> ptr == $past(ptr) + ONE);

   // R11
   ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_wr && host_idx == IDX_PTR) && !((host_wr || host_rd) && host_idx == IDX_DAT)
      |=> $stable(ptr));

   // R6
   flag_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr && host_idx == IDX_STS && !host_wdata[LOAD_BIT] && !proc_clr |=> $stable(busy));

   // R6
   flag_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr && host_idx == IDX_STS && host_wdata[LOAD_BIT] && !proc_clr
      |=> busy == $past(host_wdata[FLAG_BIT]));

   // R8
   flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      proc_clr |=> !busy);

   // R7
   sts_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_rd && !host_wr && host_idx == IDX_STS |=> $countones(host_rdata) <= 1);

   // R11
   unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_rd && !host_wr && !mapped |=> host_rdata == '0);
endmodule

bind cmd_mailbox cmd_mailbox_chk #(
   .IDX_W(IDX_W), .DW(DW), .AW(AW),
   .IDX_PTR(IDX_PTR), .IDX_DAT(IDX_DAT), .IDX_STS(IDX_STS),
   .FLAG_BIT(FLAG_BIT), .LOAD_BIT(LOAD_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
   .host_idx(host_idx), .host_wdata(host_wdata), .host_rdata(host_rdata),
   .proc_clr(proc_clr), .busy(busy_q), .ptr(ptr_q)
);

// File: tb/cmd_mailbox_bench.sv
module cmd_mailbox_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 16;
   localparam int AW    = 4;
   localparam logic [7:0] I_PTR = 8'hA6;
   localparam logic [7:0] I_DAT = 8'hA7;
   localparam logic [7:0] I_STS = 8'hA8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic host_wr = 1'b0, host_rd = 1'b0;
   logic [7:0] host_idx = '0, host_wdata = '0;
   logic [7:0] host_rdata;
   logic proc_we = 1'b0;
   logic [AW-1:0] proc_addr = '0;
   logic [7:0] proc_wdata = '0;
   logic [7:0] proc_rdata;
   logic proc_clr = 1'b0;
   logic req_busy;

   int n_cmp = 0, n_bad = 0, cycles = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cmd_mailbox #(.DEPTH(DEPTH)) u_cmd_mailbox (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
      .host_idx(host_idx), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .proc_we(proc_we), .proc_addr(proc_addr), .proc_wdata(proc_wdata),
      .proc_rdata(proc_rdata), .proc_clr(proc_clr), .req_busy(req_busy)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic hwr(input logic [7:0] idx, input logic [7:0] d);
      @(negedge clk);
      host_wr = 1'b1; host_idx = idx; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic hrd(input logic [7:0] idx, output logic [7:0] d);
      @(negedge clk);
      host_rd = 1'b1; host_idx = idx;
      @(negedge clk);
      host_rd = 1'b0;
      d = host_rdata;
   endtask

   task automatic prd(input logic [AW-1:0] a, output logic [7:0] d);
      @(negedge clk);
      proc_addr = a;
      @(negedge clk);
      d = proc_rdata;
   endtask

   function automatic logic [7:0] pat(input int i, input int seed);
      return 8'((i * 37 + seed * 11 + 5) & 8'hFF);
   endfunction

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         done = 1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] r;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 rdata", host_rdata, 8'h00);
      check("R1 busy", {7'b0, req_busy}, 8'h00);
      rst_n = 1'b1;
      hrd(I_PTR, r); check("R1 ptr", r, 8'h00);
      hrd(I_STS, r); check("R1 sts", r, 8'h00);

      // R2: pointer load sweep, reading does not advance
      for (int p = 0; p < 64; p++) begin
         hwr(I_PTR, 8'(p * 5));
         hrd(I_PTR, r); check("R2 ptr", r, 8'((p * 5) % DEPTH));
         hrd(I_PTR, r); check("R2 ptr hold", r, 8'((p * 5) % DEPTH));
      end

      // R3 R4 R5: full buffer stream, read twice through wrap
      hwr(I_PTR, 8'h00);
      for (int i = 0; i < DEPTH; i++) hwr(I_DAT, pat(i, 0));
      hrd(I_PTR, r); check("R5 wrap after write", r, 8'h00);
      for (int i = 0; i < 2 * DEPTH; i++) begin
         hrd(I_DAT, r); check("R4 data read", r, pat(i % DEPTH, 0));
      end
      hrd(I_PTR, r); check("R5 wrap after read", r, 8'h00);
      hwr(I_PTR, 8'(DEPTH - 1));
      hwr(I_DAT, 8'hC3); hwr(I_DAT, 8'h3C);
      hrd(I_PTR, r); check("R5 ptr", r, 8'h01);
      hwr(I_PTR, 8'(DEPTH - 1));
      hrd(I_DAT, r); check("R3 last", r, 8'hC3);
      hrd(I_DAT, r); check("R3 first", r, 8'h3C);

      // R6 R7: status write combinations from each flag state
      for (int s = 0; s < 2; s++) begin
         for (int v = 0; v < 4; v++) begin
            hwr(I_STS, 8'({1'b1, 1'(s)}));
            hwr(I_STS, 8'(v));
            hrd(I_STS, r);
            check("R6 R7 sts", r, (v & 2) ? 8'(v & 1) : 8'(s));
            check("R6 busy", {7'b0, req_busy}, (v & 2) ? 8'(v & 1) : 8'(s));
         end
      end

      // R8: processor clear, and clear against simultaneous set
      hwr(I_STS, 8'h03);
      @(negedge clk); proc_clr = 1'b1;
      @(negedge clk); proc_clr = 1'b0;
      hrd(I_STS, r); check("R8 clear", r, 8'h00);
      @(negedge clk);
      proc_clr = 1'b1; host_wr = 1'b1; host_idx = I_STS; host_wdata = 8'h03;
      @(negedge clk);
      proc_clr = 1'b0; host_wr = 1'b0;
      hrd(I_STS, r); check("R8 clear wins", r, 8'h00);

      // R9: request from host seen by processor, response seen by host
      hwr(I_PTR, 8'h00);
      for (int i = 0; i < DEPTH; i++) hwr(I_DAT, pat(i, 1));
      for (int i = 0; i < DEPTH; i++) begin
         prd(AW'(i), r); check("R9 proc read", r, pat(i, 1));
      end
      for (int i = 0; i < DEPTH; i++) begin
         @(negedge clk);
         proc_we = 1'b1; proc_addr = AW'(i); proc_wdata = pat(i, 2);
      end
      @(negedge clk); proc_we = 1'b0;
      hwr(I_PTR, 8'h00);
      for (int i = 0; i < DEPTH; i++) begin
         hrd(I_DAT, r); check("R9 host read", r, pat(i, 2));
      end

      // R10: collision on one location
      hwr(I_PTR, 8'h05);
      @(negedge clk);
      host_wr = 1'b1; host_idx = I_DAT; host_wdata = 8'h11;
      proc_we = 1'b1; proc_addr = 4'h5; proc_wdata = 8'h22;
      @(negedge clk);
      host_wr = 1'b0; proc_we = 1'b0;
      hrd(I_PTR, r); check("R10 ptr advanced", r, 8'h06);
      prd(4'h5, r); check("R10 proc wins", r, 8'h22);

      // R11: every unmapped index
      hwr(I_PTR, 8'h03);
      hwr(I_STS, 8'h03);
      for (int k = 0; k < 256; k++) begin
         if (k == int'(I_PTR) || k == int'(I_DAT) || k == int'(I_STS)) continue;
         hwr(8'(k), 8'hFF);
         hrd(8'(k), r); check("R11 unmapped read", r, 8'h00);
      end
      hrd(I_PTR, r); check("R11 ptr kept", r, 8'h03);
      hrd(I_STS, r); check("R11 busy kept", r, 8'h01);
      for (int i = 0; i < DEPTH; i++) begin
         prd(AW'(i), r);
         check("R11 buffer kept", r, (i == 5) ? 8'h22 : pat(i, 2));
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule